// File: doc/BRIEF.md
# SDH Receive Frame-Synchronous Descrambler

This block sits after the receive framer of an STM-N line interface and undoes the line scrambling byte by byte. Each incoming byte arrives with its row, column and slot position tags. The block XORs the byte with a pseudo-random keystream. The keystream comes from a seven-stage shift register with generator 1 + x^6 + x^7, so it repeats every 127 bits. Eight keystream bits are produced per clock, most significant bit first, so one whole byte is descrambled each cycle.

The register is forced to all ones at a fixed point in the frame: the byte just after the last J0/Z0 byte of row 1. In this position scheme that byte is row 1, column 3N+1, where N is the number of STM-0 slots. From there the register runs freely for the rest of the frame. The framing bytes of row 1 are never altered. These are A1 (columns 1..N), A2 (columns N+1..2N) and J0/Z0 (columns 2N+1..3N).

A software enable turns descrambling off. While the upstream framer reports no frame, bytes pass through unchanged and the keystream register keeps its state. The output byte, the valid strobe and the position tags all appear one clock after their input.

Top module: `sdh_rx_descrambler`

## Requirements
- R1: While rst_n is low, out_valid, out_byte, out_row, out_col and out_slot are all zero on the following clock.
- R2: out_valid, out_row, out_col and out_slot equal in_valid, in_row, in_col and in_slot of the previous clock.
- R3: A valid byte at row 1, column 3N+1 is output XORed with 0xFE, the first keystream byte from the all-ones state, when descr_en and frame_ok are high.
- R4: Each later valid byte is XORed with the next eight keystream bits of generator 1 + x^6 + x^7, MSB first. The keystream bytes start FE, 04, 18, 51 and repeat every 127 bytes.
- R5: Valid bytes at row 1, columns 1 to 3N, are output unchanged.
- R6: With descr_en low, every byte is output unchanged, and the keystream keeps advancing on each valid byte.
- R7: With frame_ok low, bytes are output unchanged and the keystream state holds; it resumes where it stopped once frame_ok returns.
- R8: A cycle with in_valid low does not advance the keystream.
- R9: Bytes in columns 1 to 3N of rows 2 to 9 are descrambled like payload bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| descr_en | input | 1 | Software descrambling enable |
| frame_ok | input | 1 | Upstream framer has frame alignment |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Scrambled byte |
| in_row | input | ROW_W | Row tag, 1 to 9 |
| in_col | input | COL_W | Column tag, 1 to 90N |
| in_slot | input | SLOT_W | Slot tag, passed through |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Descrambled byte |
| out_row | output | ROW_W | Delayed row tag |
| out_col | output | COL_W | Delayed column tag |
| out_slot | output | SLOT_W | Delayed slot tag |

## Verification
Fixed vectors at the start of row 1 separate framing bytes that pass through from the first keystream bytes after the reload. Full frames of random data, compared with an independent keystream model, test the continuous run across rows, and show that rows 2 to 9 are treated unlike row 1. Stretches with descr_en low, frame_ok low or in_valid low show the difference between the keystream running on and holding. A run of 127 zero bytes shows the sequence period.

// File: rtl/sdh_rx_descrambler.sv
module sdh_rx_descrambler #(
  parameter int N      = 3,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 10,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              descr_en,
  input  logic              frame_ok,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [COL_W-1:0]  in_col,
  input  logic [SLOT_W-1:0] in_slot,
  output logic              out_valid,
  output logic [7:0]        out_byte,
  output logic [ROW_W-1:0]  out_row,
  output logic [COL_W-1:0]  out_col,
  output logic [SLOT_W-1:0] out_slot
);
  localparam logic [COL_W-1:0] OH_LAST    = COL_W'(3 * N);
  localparam logic [COL_W-1:0] RELOAD_COL = COL_W'(3 * N + 1);

  logic [6:0] prbs_q, seed, prbs_nxt;
  logic [7:0] mask;

  wire at_row1  = (in_row == ROW_W'(1));
  wire is_fixed = at_row1 && (in_col != '0) && (in_col <= OH_LAST);
  wire reload   = at_row1 && (in_col == RELOAD_COL);
  wire advance  = in_valid && frame_ok;
  wire apply    = frame_ok && descr_en && !is_fixed;

  assign seed = reload ? 7'h7F : prbs_q;

  always_comb begin
    logic [6:0] s;
    s = seed;
    for (int i = 0; i < 8; i++) begin
      mask[7-i] = s[6];
      s = {s[5:0], s[5] ^ s[6]};
    end
    prbs_nxt = s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prbs_q    <= 7'h7F;
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_row   <= '0;
      out_col   <= '0;
      out_slot  <= '0;
    end else begin
      if (advance) prbs_q <= prbs_nxt;
      out_valid <= in_valid;
      out_byte  <= apply ? (in_byte ^ mask) : in_byte;
      out_row   <= in_row;
      out_col   <= in_col;
      out_slot  <= in_slot;
    end
  end

  AST_TAG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid) && out_row == $past(in_row) && out_col == $past(in_col))); // R2
  AST_FIRST_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && frame_ok && descr_en && reload) |=> (out_byte == ($past(in_byte) ^ 8'hFE))); // R3
  AST_OH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_fixed) |=> (out_byte == $past(in_byte))); // R5
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !descr_en) |=> (out_byte == $past(in_byte))); // R6
  AST_HOLD_NOFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_ok) |=> (prbs_q == $past(prbs_q))); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid) |=> (prbs_q == $past(prbs_q))); // R8
endmodule

// File: tb/test_sdh_rx_descrambler.sv
module test_sdh_rx_descrambler;
  localparam int N = 3;
  localparam int ROW_W = 4, COL_W = 10, SLOT_W = 4;
  localparam int OH = 3 * N;
  localparam int NCOL = 90 * N;

  logic clk = 0, rst_n = 0, descr_en = 0, frame_ok = 0, in_valid = 0;
  logic [7:0] in_byte = 0;
  logic [ROW_W-1:0] in_row = 0;
  logic [COL_W-1:0] in_col = 0;
  logic [SLOT_W-1:0] in_slot = 0;
  logic out_valid;
  logic [7:0] out_byte;
  logic [ROW_W-1:0] out_row;
  logic [COL_W-1:0] out_col;
  logic [SLOT_W-1:0] out_slot;

  int total = 0, bad = 0;
  logic [6:0] rs = 7'h7F;

  always #2 clk = ~clk;

  sdh_rx_descrambler #(.N(N), .ROW_W(ROW_W), .COL_W(COL_W), .SLOT_W(SLOT_W)) i_sdh_rx_descrambler (
    .clk(clk), .rst_n(rst_n), .descr_en(descr_en), .frame_ok(frame_ok), .in_valid(in_valid),
    .in_byte(in_byte), .in_row(in_row), .in_col(in_col), .in_slot(in_slot),
    .out_valid(out_valid), .out_byte(out_byte), .out_row(out_row), .out_col(out_col), .out_slot(out_slot));

  // {column, input byte, expected output} for row 1, descr_en and frame_ok high
  localparam logic [23:0] VEC [13] = '{
    {8'd1, 8'hF6, 8'hF6}, {8'd2, 8'hF6, 8'hF6}, {8'd3, 8'hF6, 8'hF6},
    {8'd4, 8'h28, 8'h28}, {8'd5, 8'h28, 8'h28}, {8'd6, 8'h28, 8'h28},
    {8'd7, 8'h01, 8'h01}, {8'd8, 8'h02, 8'h02}, {8'd9, 8'h03, 8'h03},
    {8'd10, 8'h00, 8'hFE}, {8'd11, 8'h00, 8'h04}, {8'd12, 8'hFF, 8'hE7},
    {8'd13, 8'h51, 8'h00}};

  function automatic logic [7:0] key_byte(inout logic [6:0] st);
    logic [7:0] k;
    for (int i = 0; i < 8; i++) begin
      k = {k[6:0], st[6]};
      st = {st[5:0], st[6] ^ st[5]};
    end
    return k;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic fok, input logic en, input int row, input int col,
                      input logic [7:0] d, input logic use_tab, input logic [7:0] tab, input string req);
    logic [7:0] k, exp;
    logic fixed;
    k = 8'h00;
    in_valid = v; frame_ok = fok; descr_en = en; in_byte = d;
    in_row = ROW_W'(row); in_col = COL_W'(col); in_slot = SLOT_W'((col - 1) % N);
    fixed = (row == 1) && (col >= 1) && (col <= OH);
    if (v && fok) begin
      if (row == 1 && col == OH + 1) rs = 7'h7F;
      k = key_byte(rs);
    end
    exp = (fok && en && !fixed) ? (d ^ k) : d;
    if (use_tab) exp = tab;
    @(posedge clk); #1;
    check({req, " valid"}, 32'(out_valid), 32'(v));
    check("R2 tags", {out_row, out_col, out_slot}, {in_row, in_col, in_slot});
    if (v) check({req, " byte"}, 32'(out_byte), 32'(exp));
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    in_valid = 1; in_byte = 8'hA5; in_row = 1; in_col = 5; in_slot = 2; frame_ok = 1; descr_en = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", 32'(out_valid), 0);
    check("R1 reset byte", 32'(out_byte), 0);
    check("R1 reset tags", {out_row, out_col, out_slot}, 0);
    rst_n = 1;

    // table walk: framing bytes then first keystream bytes (R5, R3, R4)
    foreach (VEC[i]) begin
      int c;
      c = int'(VEC[i][23:16]);
      step(1, 1, 1, 1, c, VEC[i][15:8], 1, VEC[i][7:0], c <= OH ? "R5" : (c == OH + 1 ? "R3" : "R4"));
    end

    // two full frames of random data against the model, with idle gaps in the second (R4, R9, R8)
    for (int f = 0; f < 2; f++)
      for (int r = 1; r <= 9; r++)
        for (int c = 1; c <= NCOL; c++) begin
          if (f == 1 && c % 50 == 0) step(0, 1, 1, r, c, 8'h3C, 0, 0, "R8");
          step(1, 1, 1, r, c, 8'($urandom), 0, 0,
               (r == 1 && c <= OH) ? "R5" : (r > 1 && c <= OH) ? "R9" : (f == 1 ? "R8" : "R4"));
        end

    // frame loss: passthrough and hold, then resume (R7); software bypass (R6)
    for (int c = 1; c <= OH; c++) step(1, 1, 1, 1, c, 8'h11, 0, 0, "R5");
    for (int c = OH + 1; c <= 40; c++) step(1, 1, 1, 1, c, 8'($urandom), 0, 0, "R4");
    for (int c = 41; c <= 60; c++) step(1, 0, 1, 1, c, 8'($urandom), 0, 0, "R7");
    for (int c = 61; c <= 80; c++) step(1, 1, 1, 1, c, 8'($urandom), 0, 0, "R7");
    for (int c = 81; c <= 110; c++) step(1, 1, 0, 1, c, 8'($urandom), 0, 0, "R6");
    for (int c = 111; c <= 130; c++) step(1, 1, 1, 1, c, 8'($urandom), 0, 0, "R6");

    // keystream period of 127 bytes after reload (R4)
    for (int c = 1; c <= OH; c++) step(1, 1, 1, 1, c, 8'h00, 0, 0, "R5");
    for (int c = OH + 1; c <= OH + 127; c++) step(1, 1, 1, 1, c, 8'h00, 0, 0, "R4");
    step(1, 1, 1, 1, OH + 128, 8'h00, 1, 8'hFE, "R4 period");
    step(1, 1, 1, 1, OH + 129, 8'h00, 1, 8'h04, "R4 period");

    in_valid = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule